// File: doc/BRIEF.md
# Stop-Mode Clock Gating Controller

This block puts a small microcontroller clock system into a low-power stop state and brings it back out. Software writes a stop request into a power-control register. If the CPU is running from the main clock, the controller turns off the main oscillator and gates the CPU clock and most peripheral clocks. Registers and RAM are left untouched. A peripheral whose count clock or serial clock comes from a source that keeps running during stop keeps its clock enable. These sources are the sub (watch) clock for timers and an external serial clock for serial channels. The watchdog, I2C, A/D and DMA clocks are always turned off.

A wake event ends the stop state. If a resonator is fitted, the controller waits for the oscillator to settle. The wait is a programmable count of 2^N controller-clock cycles, and the CPU clock stays off until it ends. If an external clock is fitted instead, the CPU clock comes back on the first edge after wake. When the controller returns to running, it clears the stop request itself. A stop request made while the sub clock drives the CPU is refused and flagged. A request that arrives together with a wake event is dropped without error.

The controller runs from a free-running control clock. It drives only enable outputs, so the oscillators and the clock gates remain outside the block.

Top module: `stop_clk_ctrl`

## Requirements
- R1: After reset the controller is running. CPU, main oscillator, sub feedback and every peripheral clock enable are 1, `entry_err` is 0, and both registers read 0.
- R2: A write to address 0 with bit 0 set is accepted when the clock-control register (address 1) bit 1 is 0 and `wake` is low. From the next cycle, `cpu_clk_en`, `main_osc_en`, `wdt_clk_en`, `i2c_clk_en`, `adc_clk_en` and `dma_clk_en` are all 0.
- R3: A stop request made while address 1 bit 1 is 1 (CPU on the sub clock) is ignored. All enables stay 1, the stop bit reads 0, and `entry_err` is 1 for exactly the one cycle after the write.
- R4: While stopped or settling, `tmr_clk_en[i]` equals `tmr_sub_sel[i]`. While running, every timer enable is 1.
- R5: While stopped or settling, `ser_clk_en[i]` equals `ser_ext_sel[i]`. While running, every serial enable is 1.
- R6: `sub_fb_en` is 0 only in the stop state while the feedback-cut bit (address 1 bit 0) is 1. It is 1 at all other times.
- R7: When address 0 bit 1 is 0 (resonator fitted), `cpu_clk_en` stays 0 for exactly 2^N cycles after the edge that samples `wake`. N is address 0 bits [4:2]. `main_osc_en` is 1 during this wait.
- R8: When address 0 bit 1 is 1, `cpu_clk_en` is 1 immediately after the edge that samples `wake`.
- R9: While stopped, address 0 bit 0 reads 1. It reads 0 once the controller is running again.
- R10: A stop request written in the same cycle as `wake` leaves the controller running, with the stop bit 0 and `entry_err` 0.
- R11: Register writes made while stopped or settling have no effect. The settle time and the read-back values stay those set before entry.
- R12: The wait field, the bypass bit, the feedback-cut bit and the clock-select bit keep their values across a full stop and wake sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 power control, 1 clock control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read register select |
| rd_data | output | 8 | Read data of the selected register |
| wake | input | 1 | Wake event, synchronous to clk |
| tmr_sub_sel | input | NUM_TMR | Timer i counts from the sub clock or the watch interrupt |
| ser_ext_sel | input | NUM_SER | Serial channel i uses an external serial clock |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_fb_en | output | 1 | Sub oscillator feedback enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | NUM_TMR | Timer clock enables |
| ser_clk_en | output | NUM_SER | Serial channel clock enables |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| i2c_clk_en | output | 1 | I2C clock enable |
| adc_clk_en | output | 1 | A/D converter clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| entry_err | output | 1 | One-cycle flag for a refused stop request |

## Verification
The bench builds the block with its defaults: six timers, three serial channels and a 3-bit wait exponent. This gives every wait length from 1 to 128 cycles, and the bench sweeps N over all eight values, measuring each resulting dark period cycle by cycle. Six timers and three channels allow random keep-alive masks with enough mixtures of set and clear bits that a swapped or stuck enable shows up.

// File: rtl/stop_clk_pkg.sv
package stop_clk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } pwr_state_e;

  // power-control register (address 0) field positions
  localparam int PWR_IDX_STOP = 0;
  localparam int PWR_IDX_BYP  = 1;
  localparam int PWR_IDX_EXP  = 2;
  // clock-control register (address 1) field positions
  localparam int CLK_IDX_FBC  = 0;
  localparam int CLK_IDX_SUB  = 1;
endpackage

// File: rtl/stop_rst_sync.sv
module stop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/stop_regs.sv
module stop_regs #(
  parameter int DATA_W = 8,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  input  logic              in_run,
  input  logic              set_stop,
  input  logic              clr_stop,
  output logic [DATA_W-1:0] rd_data,
  output logic              stop_wr,
  output logic              stop_bit,
  output logic              bypass,
  output logic [EXP_W-1:0]  wait_exp,
  output logic              fb_cut,
  output logic              cpu_sub
);
  import stop_clk_pkg::*;

  logic             stop_d, byp_d, fbc_d, sub_d;
  logic [EXP_W-1:0] exp_d;
  logic             wr_pwr, wr_clk;

  assign wr_pwr  = wr_en && in_run && (wr_addr == 1'b0);
  assign wr_clk  = wr_en && in_run && (wr_addr == 1'b1);
  assign stop_wr = wr_pwr && wr_data[PWR_IDX_STOP];

  always_comb begin
    stop_d = stop_bit;
    byp_d  = bypass;
    exp_d  = wait_exp;
    fbc_d  = fb_cut;
    sub_d  = cpu_sub;
    if (set_stop)      stop_d = 1'b1;
    else if (clr_stop) stop_d = 1'b0;
    if (wr_pwr) begin
      byp_d = wr_data[PWR_IDX_BYP];
      exp_d = wr_data[PWR_IDX_EXP +: EXP_W];
    end
    if (wr_clk) begin
      fbc_d = wr_data[CLK_IDX_FBC];
      sub_d = wr_data[CLK_IDX_SUB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_bit <= 1'b0;
      bypass   <= 1'b0;
      wait_exp <= '0;
      fb_cut   <= 1'b0;
      cpu_sub  <= 1'b0;
    end else begin
      stop_bit <= stop_d;
      bypass   <= byp_d;
      wait_exp <= exp_d;
      fb_cut   <= fbc_d;
      cpu_sub  <= sub_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == 1'b0) begin
      rd_data[PWR_IDX_STOP]          = stop_bit;
      rd_data[PWR_IDX_BYP]           = bypass;
      rd_data[PWR_IDX_EXP +: EXP_W]  = wait_exp;
    end else begin
      rd_data[CLK_IDX_FBC] = fb_cut;
      rd_data[CLK_IDX_SUB] = cpu_sub;
    end
  end

  // R11
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_run) |=> ($stable(wait_exp) && $stable(bypass) &&
                            $stable(fb_cut) && $stable(cpu_sub)));
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm #(
  parameter int EXP_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stop_wr,
  input  logic                     cpu_sub,
  input  logic                     wake,
  input  logic                     bypass,
  input  logic [EXP_W-1:0]         wait_exp,
  output stop_clk_pkg::pwr_state_e state_q,
  output logic                     set_stop,
  output logic                     clr_stop,
  output logic                     entry_err
);
  import stop_clk_pkg::*;

  localparam int CNT_W = (1 << EXP_W) - 1;

  pwr_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             err_d;

  assign lim      = ~({CNT_W{1'b1}} << wait_exp);
  assign set_stop = stop_wr && !cpu_sub && !wake;
  assign err_d    = stop_wr && cpu_sub;
  assign clr_stop = (state_q != ST_RUN) && (state_d == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (set_stop) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (wake) begin
          cnt_d   = '0;
          state_d = bypass ? ST_RUN : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cnt_q == lim) state_d = ST_RUN;
        else              cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      cnt_q     <= '0;
      entry_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      entry_err <= err_d;
    end
  end

  // R3
  sub_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && cpu_sub) |=> (state_q == ST_RUN && entry_err));
  // R10
  wake_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && wake) |=> (state_q == ST_RUN));
  // R8
  bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && wake && bypass) |=> (state_q == ST_RUN));
  // R7
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cnt_q != lim) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/stop_gate.sv
module stop_gate #(
  parameter int NUM_TMR = 6,
  parameter int NUM_SER = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  stop_clk_pkg::pwr_state_e state_q,
  input  logic                     fb_cut,
  input  logic [NUM_TMR-1:0]       tmr_sub_sel,
  input  logic [NUM_SER-1:0]       ser_ext_sel,
  output logic                     main_osc_en,
  output logic                     sub_fb_en,
  output logic                     cpu_clk_en,
  output logic [NUM_TMR-1:0]       tmr_clk_en,
  output logic [NUM_SER-1:0]       ser_clk_en,
  output logic                     wdt_clk_en,
  output logic                     i2c_clk_en,
  output logic                     adc_clk_en,
  output logic                     dma_clk_en
);
  import stop_clk_pkg::*;

  logic awake;

  assign awake       = (state_q == ST_RUN);
  assign cpu_clk_en  = awake;
  assign main_osc_en = (state_q != ST_STOP);
  assign sub_fb_en   = !((state_q == ST_STOP) && fb_cut);
  assign wdt_clk_en  = awake;
  assign i2c_clk_en  = awake;
  assign adc_clk_en  = awake;
  assign dma_clk_en  = awake;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign tmr_clk_en[t] = awake || tmr_sub_sel[t];
  end

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    assign ser_clk_en[s] = awake || ser_ext_sel[s];
  end

  // R2
  fixed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> !(cpu_clk_en || wdt_clk_en || i2c_clk_en || adc_clk_en || dma_clk_en));
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl #(
  parameter int DATA_W  = 8,
  parameter int EXP_W   = 3,
  parameter int NUM_TMR = 6,
  parameter int NUM_SER = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wake,
  input  logic [NUM_TMR-1:0] tmr_sub_sel,
  input  logic [NUM_SER-1:0] ser_ext_sel,
  output logic               main_osc_en,
  output logic               sub_fb_en,
  output logic               cpu_clk_en,
  output logic [NUM_TMR-1:0] tmr_clk_en,
  output logic [NUM_SER-1:0] ser_clk_en,
  output logic               wdt_clk_en,
  output logic               i2c_clk_en,
  output logic               adc_clk_en,
  output logic               dma_clk_en,
  output logic               entry_err
);
  import stop_clk_pkg::*;

  logic             rst_n_s;
  pwr_state_e       state_q;
  logic             stop_wr, set_stop, clr_stop;
  logic             stop_bit, bypass, fb_cut, cpu_sub;
  logic [EXP_W-1:0] wait_exp;

  stop_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  stop_regs #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .in_run   (state_q == ST_RUN),
    .set_stop (set_stop),
    .clr_stop (clr_stop),
    .rd_data  (rd_data),
    .stop_wr  (stop_wr),
    .stop_bit (stop_bit),
    .bypass   (bypass),
    .wait_exp (wait_exp),
    .fb_cut   (fb_cut),
    .cpu_sub  (cpu_sub)
  );

  stop_fsm #(.EXP_W(EXP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .stop_wr   (stop_wr),
    .cpu_sub   (cpu_sub),
    .wake      (wake),
    .bypass    (bypass),
    .wait_exp  (wait_exp),
    .state_q   (state_q),
    .set_stop  (set_stop),
    .clr_stop  (clr_stop),
    .entry_err (entry_err)
  );

  stop_gate #(.NUM_TMR(NUM_TMR), .NUM_SER(NUM_SER)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .state_q     (state_q),
    .fb_cut      (fb_cut),
    .tmr_sub_sel (tmr_sub_sel),
    .ser_ext_sel (ser_ext_sel),
    .main_osc_en (main_osc_en),
    .sub_fb_en   (sub_fb_en),
    .cpu_clk_en  (cpu_clk_en),
    .tmr_clk_en  (tmr_clk_en),
    .ser_clk_en  (ser_clk_en),
    .wdt_clk_en  (wdt_clk_en),
    .i2c_clk_en  (i2c_clk_en),
    .adc_clk_en  (adc_clk_en),
    .dma_clk_en  (dma_clk_en)
  );

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(cpu_clk_en) |-> !stop_bit);
  // R9
  stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !main_osc_en |-> stop_bit);
endmodule

// File: tb/stop_clk_ctrl_bench.sv
`timescale 1ns/1ps
module stop_clk_ctrl_bench;
  localparam int NT = 6;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_addr, rd_addr, wake;
  logic [7:0]    wr_data, rd_data;
  logic [NT-1:0] tmr_sub_sel, tmr_clk_en;
  logic [NS-1:0] ser_ext_sel, ser_clk_en;
  logic main_osc_en, sub_fb_en, cpu_clk_en, wdt_clk_en, i2c_clk_en;
  logic adc_clk_en, dma_clk_en, entry_err;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stop_clk_ctrl u_stop_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake(wake), .tmr_sub_sel(tmr_sub_sel),
    .ser_ext_sel(ser_ext_sel), .main_osc_en(main_osc_en), .sub_fb_en(sub_fb_en),
    .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .ser_clk_en(ser_clk_en),
    .wdt_clk_en(wdt_clk_en), .i2c_clk_en(i2c_clk_en), .adc_clk_en(adc_clk_en),
    .dma_clk_en(dma_clk_en), .entry_err(entry_err)
  );

  function automatic int exp_dark(input bit byp, input int n);
    return byp ? 0 : (1 << n);
  endfunction

  function automatic logic [7:0] pwr_word(input bit stop, input bit byp, input int n);
    return {3'b000, 3'(n), byp, stop};
  endfunction

  function automatic logic [6:0] fixed_offs();
    return {cpu_clk_en, main_osc_en, wdt_clk_en, i2c_clk_en, adc_clk_en, dma_clk_en, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d, input bit wk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wake = wk;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wake = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic do_wake(output int dark);
    wake = 1'b1;
    @(posedge clk); @(negedge clk);
    wake = 1'b0;
    dark = 0;
    while (!cpu_clk_en && dark < 1000) begin
      dark++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int dark;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    wake = 1'b0; tmr_sub_sel = '0; ser_ext_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 fixed", int'(fixed_offs()), 7'b1111110);
    chk("R1 tmr", int'(tmr_clk_en), {NT{1'b1}});
    chk("R1 ser", int'(ser_clk_en), {NS{1'b1}});
    chk("R1 fb", int'(sub_fb_en), 1);
    chk("R1 err", int'(entry_err), 0);
    rd(1'b0, r); chk("R1 pwr reg", int'(r), 0);
    rd(1'b1, r); chk("R1 clk reg", int'(r), 0);

    // R3 refused on sub clock
    wr(1'b1, 8'h02, 1'b0);
    wr(1'b0, pwr_word(1, 0, 2), 1'b0);
    chk("R3 cpu stays", int'(cpu_clk_en), 1);
    chk("R3 osc stays", int'(main_osc_en), 1);
    chk("R3 err pulse", int'(entry_err), 1);
    rd(1'b0, r); chk("R3 stop bit", int'(r[0]), 0);
    @(negedge clk);
    chk("R3 err one cycle", int'(entry_err), 0);
    wr(1'b1, 8'h00, 1'b0);

    // R10 wake collides with request
    wr(1'b0, pwr_word(1, 1, 0), 1'b1);
    chk("R10 cpu stays", int'(cpu_clk_en), 1);
    chk("R10 no err", int'(entry_err), 0);
    rd(1'b0, r); chk("R10 stop bit", int'(r[0]), 0);
    repeat (2) @(negedge clk);
    chk("R10 still running", int'(main_osc_en), 1);

    // random stop/wake rounds, N swept over all values
    for (int it = 0; it < 32; it++) begin
      int n;
      bit byp, fbc, poke;
      logic [NT-1:0] ts;
      logic [NS-1:0] ss;
      n = it % 8;
      byp = (it % 5 == 0) ? 1'b1 : 1'($urandom % 2);
      fbc = 1'($urandom % 2);
      poke = (it % 3 == 1);
      ts = NT'($urandom);
      ss = NS'($urandom);
      tmr_sub_sel = ts; ser_ext_sel = ss;
      wr(1'b1, {6'b0, 1'b0, fbc}, 1'b0);
      wr(1'b0, pwr_word(1, byp, n), 1'b0);
      chk("R2 fixed off", int'(fixed_offs()), 0);
      chk("R4 tmr keep", int'(tmr_clk_en), int'(ts));
      chk("R5 ser keep", int'(ser_clk_en), int'(ss));
      chk("R6 fb in stop", int'(sub_fb_en), int'(!fbc));
      rd(1'b0, r); chk("R9 stop bit set", int'(r[0]), 1);
      repeat (1 + $urandom % 4) @(negedge clk);
      if (poke) begin
        wr(1'b0, pwr_word(0, !byp, (n + 3) % 8), 1'b0);
        wr(1'b1, {6'b0, 1'b1, !fbc}, 1'b0);
        rd(1'b0, r); chk("R11 pwr frozen", int'(r), int'(pwr_word(1, byp, n)));
      end
      do_wake(dark);
      chk(byp ? "R8 bypass dark" : "R7 settle dark", dark, exp_dark(byp, n));
      rd(1'b0, r); chk("R12 pwr kept", int'(r), int'(pwr_word(0, byp, n)));
      rd(1'b1, r); chk("R12 clk kept", int'(r), int'({6'b0, 1'b0, fbc}));
      chk("R4 tmr run", int'(tmr_clk_en), {NT{1'b1}});
      chk("R5 ser run", int'(ser_clk_en), {NS{1'b1}});
      chk("R6 fb run", int'(sub_fb_en), 1);
    end

    // R7 oscillator on during settle
    wr(1'b0, pwr_word(1, 0, 3), 1'b0);
    wake = 1'b1; @(posedge clk); @(negedge clk); wake = 1'b0;
    chk("R7 osc on in wait", int'(main_osc_en), 1);
    chk("R7 cpu off in wait", int'(cpu_clk_en), 0);
    chk("R6 fb on in wait", int'(sub_fb_en), 1);
    repeat (8) @(negedge clk);
    chk("R7 cpu back", int'(cpu_clk_en), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule